// File: doc/BRIEF.md
# Pipelined Floating-Point Adder-Subtractor

This block adds or subtracts two binary floating-point numbers. Each number has a sign bit, a biased exponent and a fraction. The format is set by two parameters: `EXP_W` is the exponent width, and `FRAC_W` is the fraction width counted with the hidden leading one. The total word is `EXP_W + FRAC_W` bits and the exponent bias is `2^(EXP_W-1)-1`. The defaults give the 32-bit single-precision layout. The block accepts one operation per clock and returns each result a fixed three enabled clocks later. Each result comes with a valid strobe and overflow, underflow and invalid-operation flags that are aligned to it.

Subnormal values are not supported. A subnormal input counts as a zero with its own sign, and a result too small to be normal is replaced by a signed zero. Rounding is always to the nearest value, with ties going to the even neighbour. Every NaN is treated as quiet. Any NaN the block produces has one fixed pattern: negative sign, all-ones exponent and only the top stored fraction bit set.

Control works as follows. An operation is taken on an enabled clock edge when the caller's new-data strobe and the block's ready output are both high. A synchronous active-low clear empties the control pipeline and takes priority over the clock enable. While the clock enable is low, the whole block is frozen.

Top module: `fp_addsub_pipe`

## Requirements
- R1: For finite operands the result is the exact sum rounded to the nearest representable value. The result word is {sign, biased exponent, fraction without the hidden bit}, MSB first, and the bias is 2^(EXP_W-1)-1.
- R2: An op_code of 6'b000001 computes op_a - op_b. Every other op_code value, including 6'b000000, computes op_a + op_b.
- R3: An operation is accepted on an edge where ce, in_valid and in_ready are all high. Its result appears with res_valid high after exactly three enabled edges, in issue order. One operation can be accepted on every enabled edge.
- R4: When the exact sum lies exactly halfway between two representable values, the neighbour with an even last fraction bit is chosen.
- R5: An operand with a zero exponent field counts as a zero that keeps its sign bit, whatever its fraction field holds.
- R6: An exactly zero sum is -0 only when both effective operand signs are negative (the sign of op_b is inverted for subtraction). Otherwise it is +0.
- R7: If either operand is a NaN (all-ones exponent, non-zero fraction), the result is the canonical NaN and inv stays low. The canonical NaN has sign 1, an all-ones exponent and a fraction with only its MSB set.
- R8: Infinities of opposite effective sign give the canonical NaN with inv high. Any other case with an infinite operand gives that infinity with its effective sign.
- R9: If the rounded exponent reaches the all-ones value, the result is an infinity of the sum's sign and ovf is high.
- R10: If a non-zero sum rounds to an exponent of zero or below, the result is a zero of the sum's sign and unf is high. No result ever has a zero exponent field with a non-zero fraction.
- R11: At most one of ovf, unf and inv is high with any valid result. Each flag belongs to the result shown in the same cycle.
- R12: The clear is synchronous and takes priority over ce. From the first edge with rst_n low, in_ready and res_valid are low and all in-flight operations are dropped. in_ready goes high again on the first enabled edge after rst_n returns high.
- R13: While ce is low, every output and every piece of internal state holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low clear of the control path |
| ce | input | 1 | Clock enable; low freezes the block |
| in_valid | input | 1 | New operands and op_code are present |
| in_ready | output | 1 | Block can take an operation |
| op_code | input | 6 | Operation select (subtract on 6'b000001) |
| op_a | input | EXP_W+FRAC_W | First operand |
| op_b | input | EXP_W+FRAC_W | Second operand |
| res_valid | output | 1 | res and the flags hold a result |
| res | output | EXP_W+FRAC_W | Rounded result |
| ovf | output | 1 | Overflow to infinity |
| unf | output | 1 | Underflow flushed to zero |
| inv | output | 1 | Invalid operation (opposite infinities) |

## Verification
The assertions assume that ce and rst_n come from synchronous logic and are stable around the clock edge. They also assume that the data and flag outputs are only meaningful when res_valid is high, so every data check is gated by that strobe. The stimulus keeps within this: all inputs are driven on the falling edge, ce is lowered only with in_valid low, and the clear is applied only after the stream in flight has been noted as discarded. An 8-bit format (4-bit exponent, 4-bit fraction with hidden bit) is swept over every operand pair for both addition and subtraction. The expected results come from exact integer arithmetic on scaled values.

// File: rtl/fp_addsub_pkg.sv
// Shared types for the floating-point adder-subtractor.
// Assumes: nothing; pure declarations.
package fp_addsub_pkg;

    // Class of a value travelling down the pipeline.
    typedef enum logic [1:0] {
        FK_NUM  = 2'd0,
        FK_ZERO = 2'd1,
        FK_INF  = 2'd2,
        FK_NAN  = 2'd3
    } fp_kind_e;

    localparam logic [5:0] OPC_ADD = 6'b000000;
    localparam logic [5:0] OPC_SUB = 6'b000001;

    // Guard, round and sticky bits kept below the significand.
    localparam int GRS_W = 3;

endpackage

// File: rtl/fp_align_stage.sv
// Stage 1: unpacks both operands, flushes subnormals to signed zero,
// classifies the special cases, orders the operands by magnitude and
// shifts the smaller significand right with guard/round/sticky bits.
// Assumes: FRAC_W >= 3 and EXP_W >= 3.
module fp_align_stage
    import fp_addsub_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 24,
    localparam int W  = EXP_W + FRAC_W,
    localparam int MW = FRAC_W + GRS_W,
    localparam int XW = EXP_W + 2
) (
    input  logic                 clk,
    input  logic                 ce,
    input  logic [W-1:0]         a_i,
    input  logic [W-1:0]         b_i,
    input  logic                 sub_i,
    output fp_kind_e             kind_o,
    output logic                 sign_o,
    output logic                 zsign_o,
    output logic                 effsub_o,
    output logic                 inv_o,
    output logic signed [XW-1:0] exp_o,
    output logic [MW-1:0]        big_o,
    output logic [MW-1:0]        small_o
);

    logic               sa, sb;
    logic [EXP_W-1:0]   ea, eb, e_big, e_sm, diff;
    logic [FRAC_W-2:0]  fa, fb;
    logic               a_nan, a_inf, a_zero, b_nan, b_inf, b_zero;
    logic [FRAC_W-1:0]  ma, mb, m_big, m_sm;
    logic               a_ge;
    logic               s_big;
    logic [MW-1:0]      ext, sh;
    logic               st;
    fp_kind_e           kind_n;
    logic               sign_n, inv_n;

    assign sa     = a_i[W-1];
    assign sb     = b_i[W-1] ^ sub_i;
    assign ea     = a_i[W-2 -: EXP_W];
    assign eb     = b_i[W-2 -: EXP_W];
    assign fa     = a_i[FRAC_W-2:0];
    assign fb     = b_i[FRAC_W-2:0];
    assign a_nan  = (&ea) & (|fa);
    assign a_inf  = (&ea) & ~(|fa);
    assign a_zero = ~(|ea);
    assign b_nan  = (&eb) & (|fb);
    assign b_inf  = (&eb) & ~(|fb);
    assign b_zero = ~(|eb);
    assign ma     = a_zero ? '0 : {1'b1, fa};
    assign mb     = b_zero ? '0 : {1'b1, fb};

    // Magnitude order on {exponent, flushed fraction}; ties keep op_a as big.
    assign a_ge  = {ea, ma} >= {eb, mb};
    assign e_big = a_ge ? ea : eb;
    assign e_sm  = a_ge ? eb : ea;
    assign m_big = a_ge ? ma : mb;
    assign m_sm  = a_ge ? mb : ma;
    assign s_big = a_ge ? sa : sb;
    assign diff  = e_big - e_sm;
    assign ext   = {m_sm, {GRS_W{1'b0}}};

    // Right shift of the smaller significand, folding lost bits into sticky.
    always_comb begin
        if (32'(diff) >= MW) begin
            sh = '0;
            st = |ext;
        end else begin
            sh = ext >> diff;
            st = |(ext & ~({MW{1'b1}} << diff));
        end
    end

    // Special-value classification with NaN taking precedence.
    always_comb begin
        kind_n = FK_NUM;
        sign_n = s_big;
        inv_n  = 1'b0;
        if (a_nan || b_nan) begin
            kind_n = FK_NAN;
        end else if (a_inf && b_inf && (sa != sb)) begin
            kind_n = FK_NAN;
            inv_n  = 1'b1;
        end else if (a_inf) begin
            kind_n = FK_INF;
            sign_n = sa;
        end else if (b_inf) begin
            kind_n = FK_INF;
            sign_n = sb;
        end
    end

    // Stage register, advanced only on enabled edges.
    always_ff @(posedge clk) begin
        if (ce) begin
            kind_o   <= kind_n;
            sign_o   <= sign_n;
            zsign_o  <= sa & sb;
            effsub_o <= sa ^ sb;
            inv_o    <= inv_n;
            exp_o    <= signed'({2'b00, e_big});
            big_o    <= {m_big, {GRS_W{1'b0}}};
            small_o  <= {sh[MW-1:1], sh[0] | st};
        end
    end

endmodule

// File: rtl/fp_norm_stage.sv
// Stage 2: adds or subtracts the aligned significands and normalizes the
// sum so that its leading one sits in the top bit, adjusting the exponent.
// Assumes: big_i >= small_i as magnitudes, so the difference is never negative.
module fp_norm_stage
    import fp_addsub_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 24,
    localparam int MW  = FRAC_W + GRS_W,
    localparam int XW  = EXP_W + 2,
    localparam int LZW = $clog2(MW + 1)
) (
    input  logic                 clk,
    input  logic                 ce,
    input  fp_kind_e             kind_i,
    input  logic                 sign_i,
    input  logic                 zsign_i,
    input  logic                 effsub_i,
    input  logic                 inv_i,
    input  logic signed [XW-1:0] exp_i,
    input  logic [MW-1:0]        big_i,
    input  logic [MW-1:0]        small_i,
    output fp_kind_e             kind_o,
    output logic                 sign_o,
    output logic                 inv_o,
    output logic signed [XW-1:0] exp_o,
    output logic [MW-1:0]        norm_o
);

    logic [MW:0]          sum;
    logic [LZW-1:0]       lz;
    logic [MW-1:0]        norm_n;
    logic signed [XW-1:0] exp_n;
    fp_kind_e             kind_n;
    logic                 sign_n;

    assign sum = effsub_i ? ({1'b0, big_i} - {1'b0, small_i})
                          : ({1'b0, big_i} + {1'b0, small_i});

    // Leading-zero count of the low MW bits of the sum.
    always_comb begin
        lz = '0;
        for (int i = 0; i < MW; i++) begin
            if (sum[i]) lz = LZW'(MW - 1 - i);
        end
    end

    // Normalization: right by one on carry, otherwise left by the zero count.
    always_comb begin
        if (sum[MW]) begin
            norm_n = {sum[MW:2], sum[1] | sum[0]};
            exp_n  = exp_i + XW'(1);
        end else begin
            norm_n = sum[MW-1:0] << lz;
            exp_n  = exp_i - XW'(lz);
        end
    end

    // An exact zero sum of ordinary operands takes the zero-sign rule.
    always_comb begin
        kind_n = kind_i;
        sign_n = sign_i;
        if (kind_i == FK_NUM && sum == '0) begin
            kind_n = FK_ZERO;
            sign_n = zsign_i;
        end
    end

    // Stage register, advanced only on enabled edges.
    always_ff @(posedge clk) begin
        if (ce) begin
            kind_o <= kind_n;
            sign_o <= sign_n;
            inv_o  <= inv_i;
            exp_o  <= exp_n;
            norm_o <= norm_n;
        end
    end

endmodule

// File: rtl/fp_round_stage.sv
// Stage 3: rounds the normalized significand to nearest-even, then
// resolves overflow, underflow and the special classes into the packed
// result word and its flags.
// Assumes: norm_i has its MSB set whenever kind_i is FK_NUM.
module fp_round_stage
    import fp_addsub_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 24,
    localparam int W  = EXP_W + FRAC_W,
    localparam int MW = FRAC_W + GRS_W,
    localparam int XW = EXP_W + 2
) (
    input  logic                 clk,
    input  logic                 ce,
    input  fp_kind_e             kind_i,
    input  logic                 sign_i,
    input  logic                 inv_i,
    input  logic signed [XW-1:0] exp_i,
    input  logic [MW-1:0]        norm_i,
    output logic [W-1:0]         res_o,
    output logic                 ovf_o,
    output logic                 unf_o,
    output logic                 inv_o
);

    localparam logic signed [XW-1:0] EMAX = XW'((1 << EXP_W) - 1);
    localparam logic [W-1:0] QNAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-2){1'b0}}};

    logic [FRAC_W-1:0]    keep, mant;
    logic                 g, r, s, up;
    logic [FRAC_W:0]      rnd;
    logic signed [XW-1:0] e_r;
    logic [W-1:0]         res_n;
    logic                 ovf_n, unf_n;

    assign keep = norm_i[MW-1:GRS_W];
    assign g    = norm_i[2];
    assign r    = norm_i[1];
    assign s    = norm_i[0];
    assign up   = g & (r | s | keep[0]);
    assign rnd  = {1'b0, keep} + {{FRAC_W{1'b0}}, up};

    // Renormalize after a rounding carry out of the significand.
    always_comb begin
        if (rnd[FRAC_W]) begin
            mant = rnd[FRAC_W:1];
            e_r  = exp_i + XW'(1);
        end else begin
            mant = rnd[FRAC_W-1:0];
            e_r  = exp_i;
        end
    end

    // Final packing with range checks on the rounded exponent.
    always_comb begin
        ovf_n = 1'b0;
        unf_n = 1'b0;
        case (kind_i)
            FK_NAN:  res_n = QNAN;
            FK_INF:  res_n = {sign_i, {EXP_W{1'b1}}, {(FRAC_W-1){1'b0}}};
            FK_ZERO: res_n = {sign_i, {(W-1){1'b0}}};
            default: begin
                if (e_r >= EMAX) begin
                    res_n = {sign_i, {EXP_W{1'b1}}, {(FRAC_W-1){1'b0}}};
                    ovf_n = 1'b1;
                end else if (e_r[XW-1] || e_r == '0) begin
                    res_n = {sign_i, {(W-1){1'b0}}};
                    unf_n = 1'b1;
                end else begin
                    res_n = {sign_i, e_r[EXP_W-1:0], mant[FRAC_W-2:0]};
                end
            end
        endcase
    end

    // Output register, advanced only on enabled edges.
    always_ff @(posedge clk) begin
        if (ce) begin
            res_o <= res_n;
            ovf_o <= ovf_n;
            unf_o <= unf_n;
            inv_o <= inv_i;
        end
    end

endmodule

// File: rtl/fp_addsub_pipe.sv
// Top: three-stage floating-point adder-subtractor with a valid pipeline,
// ready-for-data output, synchronous active-low clear of the control path
// and a global clock enable.
// Assumes: FRAC_W >= 3 and FRAC_W + 3 < 2^EXP_W; data regs are not reset.
module fp_addsub_pipe
    import fp_addsub_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 24,
    localparam int W     = EXP_W + FRAC_W,
    localparam int MW    = FRAC_W + GRS_W,
    localparam int XW    = EXP_W + 2,
    localparam int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [5:0]   op_code,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         res_valid,
    output logic [W-1:0] res,
    output logic         ovf,
    output logic         unf,
    output logic         inv
);

    logic [DEPTH-1:0]     vld_q;
    logic                 rdy_q;
    logic                 sub;

    fp_kind_e             k1, k2;
    logic                 s1, z1, es1, i1, s2, i2;
    logic signed [XW-1:0] x1, x2;
    logic [MW-1:0]        big1, small1, n2;

    assign sub       = (op_code == OPC_SUB);
    assign in_ready  = rdy_q;
    assign res_valid = vld_q[DEPTH-1];

    // Control path: clear wins over enable; valid shifts with each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            rdy_q <= 1'b0;
        end else if (ce) begin
            rdy_q <= 1'b1;
            vld_q <= {vld_q[DEPTH-2:0], in_valid & rdy_q};
        end
    end

    fp_align_stage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .clk(clk), .ce(ce), .a_i(op_a), .b_i(op_b), .sub_i(sub),
        .kind_o(k1), .sign_o(s1), .zsign_o(z1), .effsub_o(es1), .inv_o(i1),
        .exp_o(x1), .big_o(big1), .small_o(small1)
    );

    fp_norm_stage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .clk(clk), .ce(ce), .kind_i(k1), .sign_i(s1), .zsign_i(z1),
        .effsub_i(es1), .inv_i(i1), .exp_i(x1), .big_i(big1), .small_i(small1),
        .kind_o(k2), .sign_o(s2), .inv_o(i2), .exp_o(x2), .norm_o(n2)
    );

    fp_round_stage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .clk(clk), .ce(ce), .kind_i(k2), .sign_i(s2), .inv_i(i2),
        .exp_i(x2), .norm_i(n2),
        .res_o(res), .ovf_o(ovf), .unf_o(unf), .inv_o(inv)
    );

    AST_CLEAR_QUIET: assert property (@(posedge clk) !rst_n |=> (!in_ready && !res_valid)); // R12
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !ce |=> ($stable(res_valid) && $stable(in_ready) && $stable(res) && $stable({ovf, unf, inv}))); // R13
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $onehot0({ovf, unf, inv})); // R11
    AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && ovf) |-> ((&res[W-2 -: EXP_W]) && res[FRAC_W-2:0] == '0)); // R9
    AST_UNF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && unf) |-> (res[W-2:0] == '0)); // R10
    AST_INV_IS_NAN: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && inv) |-> (res == {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-2){1'b0}}})); // R8
    AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> !(res[W-2 -: EXP_W] == '0 && res[FRAC_W-2:0] != '0)); // R10

endmodule

// File: tb/test_fp_addsub_pipe.sv
// Bench: exhaustive add and subtract sweep of an 8-bit format (4-bit
// exponent, 4-bit significand) against exact scaled-integer arithmetic,
// plus directed latency, clock-enable and clear checks.
module test_fp_addsub_pipe;

    localparam int EW = 4;
    localparam int FW = 4;
    localparam int W  = EW + FW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ce = 1'b1;
    logic         in_valid = 1'b0;
    logic [5:0]   op_code = 6'd0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         in_ready, res_valid, ovf, unf, inv;
    logic [W-1:0] res;

    int checks = 0, failures = 0, cycles = 0;
    logic edge_en;
    int wr_ptr = 0, rd_ptr = 0;
    logic [W-1:0] q_res [16];
    logic [2:0]   q_flg [16];
    string        q_tag [16];

    always #10 clk = ~clk;

    fp_addsub_pipe #(.EXP_W(EW), .FRAC_W(FW)) i_fp_addsub_pipe (
        .clk(clk), .rst_n(rst_n), .ce(ce), .in_valid(in_valid), .in_ready(in_ready),
        .op_code(op_code), .op_a(op_a), .op_b(op_b), .res_valid(res_valid),
        .res(res), .ovf(ovf), .unf(unf), .inv(inv)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: exact sum in units of 2^-9, then round-to-nearest-even.
    function automatic void ref_op(input logic [7:0] a, input logic [7:0] b, input logic sub,
                                   output logic [7:0] r, output logic [2:0] flg, output string tag);
        int ea, eb, fa, fb, va, vb, s, mag, p, sh, q, rem, half, e;
        logic sa, sbe, sg, up, dn;
        sa = a[7]; sbe = b[7] ^ sub;
        ea = int'(a[6:3]); eb = int'(b[6:3]); fa = int'(a[2:0]); fb = int'(b[2:0]);
        flg = 3'b000; tag = "R1";
        dn = (ea == 0 && fa != 0) || (eb == 0 && fb != 0);
        if ((ea == 15 && fa != 0) || (eb == 15 && fb != 0)) begin
            r = 8'hFC; tag = "R7";
        end else if (ea == 15 && eb == 15 && sa != sbe) begin
            r = 8'hFC; flg = 3'b001; tag = "R8";
        end else if (ea == 15) begin
            r = {sa, 7'b1111000}; tag = "R8";
        end else if (eb == 15) begin
            r = {sbe, 7'b1111000}; tag = "R8";
        end else begin
            va = (ea == 0) ? 0 : ((8 + fa) << (ea - 1));
            vb = (eb == 0) ? 0 : ((8 + fb) << (eb - 1));
            s = (sa ? -va : va) + (sbe ? -vb : vb);
            if (s == 0) begin
                r = {sa & sbe, 7'b0}; tag = "R6";
            end else begin
                sg = s < 0; mag = sg ? -s : s; p = 0;
                for (int i = 0; i < 20; i++) if (((mag >> i) & 1) == 1) p = i;
                if (p < 3) begin
                    r = {sg, 7'b0}; flg = 3'b010; tag = "R10";
                end else begin
                    sh = p - 3; q = mag >> sh; rem = mag - (q << sh);
                    half = (sh > 0) ? (1 << (sh - 1)) : 0;
                    up = (rem != 0) && ((rem > half) || (rem == half && (q & 1) == 1));
                    if (rem != 0) tag = (rem == half) ? "R4" : "R1";
                    q = q + (up ? 1 : 0);
                    if (q == 16) begin q = 8; sh++; end
                    e = sh + 1;
                    if (e >= 15) begin
                        r = {sg, 7'b1111000}; flg = 3'b100; tag = "R9";
                    end else begin
                        r = {sg, e[3:0], q[2:0]};
                    end
                end
            end
        end
        if (dn) tag = {tag, "/R5"};
        if (sub) tag = {tag, "/R2"};
    endfunction

    // One falling edge: note whether the last rising edge was enabled, score outputs.
    task automatic tick();
        @(negedge clk);
        edge_en = ce;
        if (res_valid && edge_en) begin
            if (rd_ptr == wr_ptr) begin
                check(1'b0, "R3 unexpected result", int'(res), 0);
            end else begin
                check(res == q_res[rd_ptr % 16] && {ovf, unf, inv} == q_flg[rd_ptr % 16],
                      q_tag[rd_ptr % 16], int'({ovf, unf, inv, res}),
                      int'({q_flg[rd_ptr % 16], q_res[rd_ptr % 16]}));
                rd_ptr++;
            end
        end
    endtask

    task automatic issue(input logic [7:0] a, input logic [7:0] b, input logic [5:0] opc);
        logic [7:0] r; logic [2:0] f; string t;
        op_a = a; op_b = b; op_code = opc; in_valid = 1'b1;
        ref_op(a, b, opc == 6'b000001, r, f, t);
        q_res[wr_ptr % 16] = r; q_flg[wr_ptr % 16] = f; q_tag[wr_ptr % 16] = t;
        wr_ptr++;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++; checks++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", cycles, 190000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap_res;
        logic snap_v, snap_r;
        // R12: reset state
        tick(); tick(); tick();
        check(!in_ready && !res_valid, "R12 reset state", int'({in_ready, res_valid}), 0);
        rst_n = 1'b1;
        tick();
        check(in_ready, "R12 ready after release", int'(in_ready), 1);

        // R3: single-operation latency, 1.0 + 1.0 = 2.0
        issue(8'h38, 8'h38, 6'd0);
        tick(); in_valid = 1'b0;
        check(!res_valid, "R3 latency edge1", int'(res_valid), 0);
        tick();
        check(!res_valid, "R3 latency edge2", int'(res_valid), 0);
        tick();
        check(rd_ptr == 1 && res == 8'h40, "R3 latency edge3", int'(res), 8'h40);

        // Exhaustive sweep: add (some with a non-subtract code) then subtract.
        for (int k = 0; k < 131072; k++) begin
            if (k == 5000) begin
                // R13: freeze with ce low
                in_valid = 1'b0; ce = 1'b0;
                snap_res = res; snap_v = res_valid; snap_r = in_ready;
                for (int j = 0; j < 3; j++) begin
                    tick();
                    check(res == snap_res && res_valid == snap_v && in_ready == snap_r,
                          "R13 hold", int'({res_valid, res}), int'({snap_v, snap_res}));
                end
                ce = 1'b1;
            end
            issue(k[7:0], k[15:8], k[16] ? 6'b000001 : ((k % 5 == 0) ? 6'b101100 : 6'b000000));
            tick();
        end
        in_valid = 1'b0;
        for (int j = 0; j < 5; j++) tick();
        check(rd_ptr == wr_ptr, "R3 all results returned", rd_ptr, wr_ptr);

        // R12: clear drops in-flight work
        issue(8'h38, 8'h38, 6'd0); tick();
        issue(8'h40, 8'h38, 6'd1); tick();
        in_valid = 1'b0; rst_n = 1'b0;
        tick();
        check(!in_ready && !res_valid, "R12 clear quiets outputs", int'({in_ready, res_valid}), 0);
        wr_ptr = rd_ptr;
        tick();
        rst_n = 1'b1;
        tick();
        check(in_ready, "R12 ready one edge after release", int'(in_ready), 1);
        for (int j = 0; j < 4; j++) begin
            tick();
            check(!res_valid, "R12 in-flight discarded", int'(res_valid), 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule